// File: doc/BRIEF.md
# Triggered Signal Trace Recorder

The recorder captures a wide vector of internal signals into a circular sample memory on a capture clock. An arm pulse on the capture side clears the flags and starts writing one sample per cycle. Capture continues until a trigger is seen. The recorder then stores a programmed number of further samples and stops, so the memory holds history from both before and after the trigger.

The stored window is read on a separate read clock through three bus registers: control/status, post-trigger count, and read data. Writing the start bit begins a dump once the completion flag has crossed into the read domain. Each read of the data register then pops one narrow word.

A dump has a fixed layout:
- A header carrying the final write pointer and the number of valid samples.
- Every memory entry, oldest first.
- Each sample split into narrow slices, least significant slice first.

Top module: `trace_recorder`

## Requirements
- R1: After reset `triggered_o`, `completed_o` and `rd_done_o` are low, the status register reads 0 and the post-trigger count register reads 0.
- R2: A cycle with `arm_i` high clears both flags, sets the write pointer and valid count to zero and loads the post-trigger count. It overrides a trigger in the same cycle, which is then not accepted.
- R3: `trig_i` is accepted only in the pre-trigger state after arming. The trigger cycle's sample is written, and `triggered_o` is high from that clock edge on. A trigger before arming is ignored.
- R4: With post count P, exactly P samples are written after the trigger sample. `completed_o` rises P+1 edges after the trigger edge. No write occurs while `completed_o` is high.
- R5: Writes advance the pointer modulo the depth 2^ADDR_W, so the memory holds the most recent 2^ADDR_W samples. A trigger may coincide with the pointer wrap.
- R6: The dump starts with ceil((2*ADDR_W+1)/OUT_W) header words forming a vector. Its bits [ADDR_W-1:0] hold the write pointer (writes mod depth). Its bits [2*ADDR_W:ADDR_W] hold the valid count, min(writes, depth). Padding bits are zero.
- R7: After the header come all 2^ADDR_W entries, starting at the write pointer and wrapping, so the newest sample is last. Each entry is emitted as ceil(SMP_W/OUT_W) words, lowest slice first, with the top slice zero-padded.
- R8: Writing address 0 with bit 0 set starts a dump only when the synchronised completion flag is 1; otherwise it is ignored. After the last word is popped, `rd_done_o` and status bit 3 go high and the active bit clears. Data reads while inactive return 0.
- R9: Address 0 status reads as bit0 triggered, bit1 completed (both through two-flop synchronisers), bit2 dump active and bit3 dump done. Address 1 is the read/write 16-bit post count. Address 2 pops dump words, zero-extended. Address 3 reads 0. Read data appears on `bus_rdata_o` after the clock edge that samples `bus_re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| arm_i | input | 1 | Arm pulse, capture domain |
| trig_i | input | 1 | Trigger, sampled on capture clock |
| sample_i | input | SMP_W | Signals to record |
| triggered_o | output | 1 | Trigger accepted (capture domain) |
| completed_o | output | 1 | Post-trigger capture finished (capture domain) |
| rd_clk_i | input | 1 | Read/bus clock |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Registered read data |
| rd_done_o | output | 1 | Dump finished |

## Verification
Two events can fall on the same capture edge: the trigger being accepted, and the write that wraps the pointer and saturates the valid count. The bench sweeps the number of pre-trigger writes across and beyond the depth, and every post count from 0 to 9. Several combinations land the trigger sample exactly on the last address, or make the final post-trigger write the wrapping one. Each case is judged from the header's pointer and valid count and from the ordering of the dumped samples against the arithmetic sample sequence. A separate case raises arm and trigger together to check that arming wins.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned BUS_W = 16;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_PRE,
    CAP_POST,
    CAP_DONE
  } cap_state_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/trace_sync.sv
module trace_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
  parameter int unsigned DATA_W = 35,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wr_clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read side touches memory only after capture has stopped
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] post_cnt_i,
  output logic             we_o,
  output logic [ADDR_W-1:0] wptr_o,
  output logic [ADDR_W:0]  valid_o,
  output logic             triggered_o,
  output logic             completed_o
);
  localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  cap_state_e        state_q;
  logic [ADDR_W-1:0] wptr_q;
  logic [ADDR_W:0]   valid_q;
  logic [CNT_W-1:0]  rem_q;
  logic              trig_q, done_q;

  always_comb begin
    we_o = !arm_i && ((state_q == CAP_PRE) ||
                      (state_q == CAP_POST && rem_q != '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_IDLE;
      wptr_q  <= '0;
      valid_q <= '0;
      rem_q   <= '0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (arm_i) begin
      state_q <= CAP_PRE;
      wptr_q  <= '0;
      valid_q <= '0;
      rem_q   <= post_cnt_i;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (we_o) begin
        wptr_q <= wptr_q + 1'b1;
        if (valid_q != DEPTH_V) valid_q <= valid_q + 1'b1;
      end
      unique case (state_q)
        CAP_PRE: begin
          if (trig_i) begin
            state_q <= CAP_POST;
            trig_q  <= 1'b1;
          end
        end
        CAP_POST: begin
          if (rem_q == '0) begin
            state_q <= CAP_DONE;
            done_q  <= 1'b1;
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wptr_o      = wptr_q;
  assign valid_o     = valid_q;
  assign triggered_o = trig_q;
  assign completed_o = done_q;
endmodule

// File: rtl/trace_readout.sv
module trace_readout
  import trace_pkg::*;
#(
  parameter int unsigned SMP_W  = 35,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OUT_W  = 16
) (
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              trig_s_i,
  input  logic              done_s_i,
  input  logic [ADDR_W-1:0] wptr_i,
  input  logic [ADDR_W:0]   valid_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [SMP_W-1:0]  mem_rdata_i,
  output logic [CNT_W-1:0]  post_cnt_o,
  output logic              active_o,
  output logic              done_o
);
  localparam int unsigned HDR_W = 2 * ADDR_W + 1;
  localparam int unsigned HS    = ceil_div(HDR_W, OUT_W);
  localparam int unsigned SS    = ceil_div(SMP_W, OUT_W);
  localparam int unsigned MAXS  = (HS > SS) ? HS : SS;
  localparam int unsigned SL_W  = (MAXS > 1) ? $clog2(MAXS) : 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_POST = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [CNT_W-1:0]  post_q;
  logic              active_q, done_q, in_hdr_q;
  logic [SL_W-1:0]   slice_q;
  logic [ADDR_W-1:0] scnt_q, start_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [BUS_W-1:0]  rdata_q;

  logic [HS*OUT_W-1:0] hdr_pad;
  logic [SS*OUT_W-1:0] smp_pad;
  logic [OUT_W-1:0]    cur_word;

  assign mem_raddr_o = start_q + scnt_q;

  always_comb begin
    hdr_pad = '0;
    hdr_pad[HDR_W-1:0] = hdr_q;
    smp_pad = '0;
    smp_pad[SMP_W-1:0] = mem_rdata_i;
    if (in_hdr_q) cur_word = hdr_pad[int'(slice_q)*OUT_W +: OUT_W];
    else          cur_word = smp_pad[int'(slice_q)*OUT_W +: OUT_W];
  end

  always_ff @(posedge rd_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      in_hdr_q <= 1'b0;
      slice_q  <= '0;
      scnt_q   <= '0;
      start_q  <= '0;
      hdr_q    <= '0;
      rdata_q  <= '0;
    end else begin
      if (bus_we_i) begin
        if (bus_addr_i == A_CTRL && bus_wdata_i[0] && done_s_i) begin
          active_q <= 1'b1;
          done_q   <= 1'b0;
          in_hdr_q <= 1'b1;
          slice_q  <= '0;
          scnt_q   <= '0;
          start_q  <= wptr_i;
          hdr_q    <= {valid_i, wptr_i};
        end else if (bus_addr_i == A_POST) begin
          post_q <= bus_wdata_i;
        end
      end
      if (bus_re_i) begin
        unique case (bus_addr_i)
          A_CTRL: rdata_q <= BUS_W'({done_q, active_q, done_s_i, trig_s_i});
          A_POST: rdata_q <= post_q;
          A_DATA: begin
            rdata_q <= active_q ? BUS_W'(cur_word) : '0;
            if (active_q) begin
              if (in_hdr_q) begin
                if (slice_q == SL_W'(HS - 1)) begin
                  in_hdr_q <= 1'b0;
                  slice_q  <= '0;
                end else begin
                  slice_q <= slice_q + 1'b1;
                end
              end else if (slice_q == SL_W'(SS - 1)) begin
                slice_q <= '0;
                if (scnt_q == {ADDR_W{1'b1}}) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
                end else begin
                  scnt_q <= scnt_q + 1'b1;
                end
              end else begin
                slice_q <= slice_q + 1'b1;
              end
            end
          end
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata_o = rdata_q;
  assign post_cnt_o  = post_q;
  assign active_o    = active_q;
  assign done_o      = done_q;
endmodule

// File: rtl/trace_recorder.sv
module trace_recorder
  import trace_pkg::*;
#(
  parameter int unsigned SMP_W  = 35,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OUT_W  = 16
) (
  input  logic             wr_clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic [SMP_W-1:0] sample_i,
  output logic             triggered_o,
  output logic             completed_o,
  input  logic             rd_clk_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic [15:0]      bus_wdata_i,
  output logic [15:0]      bus_rdata_o,
  output logic             rd_done_o
);
  logic              mem_we;
  logic [ADDR_W-1:0] wptr, mem_raddr;
  logic [ADDR_W:0]   valid;
  logic [SMP_W-1:0]  mem_rdata;
  logic [CNT_W-1:0]  post_cnt;
  logic [1:0]        flags_s;
  logic              rd_active;

  // post count is quasi-static: written before arming, sampled at arm
  trace_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i       (wr_clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .trig_i      (trig_i),
    .post_cnt_i  (post_cnt),
    .we_o        (mem_we),
    .wptr_o      (wptr),
    .valid_o     (valid),
    .triggered_o (triggered_o),
    .completed_o (completed_o)
  );

  trace_mem #(.DATA_W(SMP_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk_i (wr_clk_i),
    .we_i     (mem_we),
    .waddr_i  (wptr),
    .wdata_i  (sample_i),
    .raddr_i  (mem_raddr),
    .rdata_o  (mem_rdata)
  );

  trace_sync #(.WIDTH(2)) u_sync (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({completed_o, triggered_o}),
    .q_o    (flags_s)
  );

  trace_readout #(.SMP_W(SMP_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rd (
    .rd_clk_i    (rd_clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .trig_s_i    (flags_s[0]),
    .done_s_i    (flags_s[1]),
    .wptr_i      (wptr),
    .valid_i     (valid),
    .mem_raddr_o (mem_raddr),
    .mem_rdata_i (mem_rdata),
    .post_cnt_o  (post_cnt),
    .active_o    (rd_active),
    .done_o      (rd_done_o)
  );
endmodule

// File: rtl/trace_recorder_chk.sv
module trace_recorder_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              trig_i,
  input logic              triggered_o,
  input logic              completed_o,
  input logic              mem_we,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W:0]   valid,
  input logic [1:0]        flags_s,
  input logic              rd_active,
  input logic              rd_done_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  AST_ARM_CLEARS: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    arm_i |=> (!triggered_o && !completed_o)); // R2
  AST_TRIG_FROM_PIN: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> $past(trig_i)); // R3
  AST_NO_WRITE_DONE: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    completed_o |-> !mem_we); // R4
  AST_DONE_AFTER_TRIG: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    completed_o |-> triggered_o); // R4
  AST_WPTR_STEP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    mem_we |=> wptr == ADDR_W'($past(wptr) + 1'b1)); // R5
  AST_VALID_BOUND: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    valid <= (ADDR_W+1)'(DEPTH)); // R6
  AST_DONE_IDLE: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_done_o |-> !rd_active); // R8
  AST_START_GATED: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $rose(rd_active) |-> $past(flags_s[1])); // R8
endmodule

bind trace_recorder trace_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .trig_i      (trig_i),
  .triggered_o (triggered_o),
  .completed_o (completed_o),
  .mem_we      (mem_we),
  .wptr        (wptr),
  .valid       (valid),
  .flags_s     (flags_s),
  .rd_active   (rd_active),
  .rd_done_o   (rd_done_o)
);

// File: tb/trace_recorder_bench.sv
module trace_recorder_bench;
  localparam int SMP_W  = 11;
  localparam int ADDR_W = 3;
  localparam int OUT_W  = 4;
  localparam int DEPTH  = 8;
  localparam int HS     = 2;
  localparam int SS     = 3;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic rst_ni = 1'b0;
  logic arm_i = 1'b0;
  logic trig_i = 1'b0;
  logic [SMP_W-1:0] sample_i = '0;
  logic triggered_o, completed_o, rd_done_o;
  logic [1:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic        bus_re_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  trace_recorder #(.SMP_W(SMP_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_trace_recorder (
    .wr_clk_i    (wr_clk),
    .rst_ni      (rst_ni),
    .arm_i       (arm_i),
    .trig_i      (trig_i),
    .sample_i    (sample_i),
    .triggered_o (triggered_o),
    .completed_o (completed_o),
    .rd_clk_i    (rd_clk),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_re_i    (bus_re_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .rd_done_o   (rd_done_o)
  );

  always #10 wr_clk = ~wr_clk;
  initial begin
    #5;
    forever #10 rd_clk = ~rd_clk;
  end

  always @(negedge wr_clk) sample_i <= sample_i + 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge rd_clk);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge rd_clk);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge rd_clk);
    bus_addr_i = a; bus_re_i = 1'b1;
    @(negedge rd_clk);
    bus_re_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic run_case(input int pre, input int post);
    logic [SMP_W-1:0] a, last;
    logic [15:0] v;
    logic [7:0]  hdr;
    logic [11:0] s;
    int writes, exp_valid, exp_wptr;
    bus_write(2'd1, 16'(post));
    @(negedge wr_clk); #1;
    a = sample_i; arm_i = 1'b1;
    for (int k = 1; k < pre; k++) begin
      @(negedge wr_clk); #1;
      arm_i = 1'b0;
    end
    @(negedge wr_clk); #1;
    arm_i = 1'b0; trig_i = 1'b1;
    @(negedge wr_clk); #1;
    trig_i = 1'b0;
    chk(triggered_o == 1'b1, "R3 triggered after trigger edge", int'(triggered_o), 1);
    chk(completed_o == 1'b0, "R4 completed early", int'(completed_o), 0);
    repeat (post) @(negedge wr_clk);
    #1;
    chk(completed_o == 1'b0, "R4 completed before P+1 edges", int'(completed_o), 0);
    @(negedge wr_clk); #1;
    chk(completed_o == 1'b1, "R4 completed at P+1 edges", int'(completed_o), 1);

    for (int k = 0; k < 20; k++) begin
      bus_read(2'd0, v);
      if (v[1]) break;
    end
    chk(v[1:0] == 2'b11, "R9 status flags synced", int'(v[1:0]), 3);

    writes    = pre + post;
    exp_valid = (writes < DEPTH) ? writes : DEPTH;
    exp_wptr  = writes % DEPTH;
    last      = a + SMP_W'(writes);

    bus_write(2'd0, 16'd1);
    hdr = '0;
    for (int j = 0; j < HS; j++) begin
      bus_read(2'd2, v);
      hdr = hdr | (8'(v[3:0]) << (4 * j));
    end
    chk(int'(hdr[2:0]) == exp_wptr, "R6 header write pointer", int'(hdr[2:0]), exp_wptr);
    chk(int'(hdr[6:3]) == exp_valid, "R6 header valid count", int'(hdr[6:3]), exp_valid);
    chk(hdr[7] == 1'b0, "R6 header padding", int'(hdr[7]), 0);

    for (int i = 0; i < DEPTH; i++) begin
      s = '0;
      for (int j = 0; j < SS; j++) begin
        bus_read(2'd2, v);
        if (j == 0) chk(v[15:4] == '0, "R9 data zero extension", int'(v[15:4]), 0);
        s = s | (12'(v[3:0]) << (4 * j));
      end
      chk(s[11] == 1'b0, "R7 top slice padding", int'(s[11]), 0);
      if (i >= DEPTH - exp_valid) begin
        logic [SMP_W-1:0] e;
        e = last - SMP_W'(DEPTH - 1 - i);
        chk(s[10:0] == e, $sformatf("R7 sample %0d pre=%0d post=%0d", i, pre, post),
            int'(s[10:0]), int'(e));
      end
    end
    bus_read(2'd0, v);
    chk(v[3:2] == 2'b10, "R8 status done and idle", int'(v[3:2]), 2);
    chk(rd_done_o == 1'b1, "R8 rd_done_o after dump", int'(rd_done_o), 1);
    bus_read(2'd2, v);
    chk(v == 16'd0, "R8 data read after dump", int'(v), 0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge wr_clk);
    #1;
    // R1 reset state
    chk(triggered_o == 1'b0, "R1 triggered_o reset", int'(triggered_o), 0);
    chk(completed_o == 1'b0, "R1 completed_o reset", int'(completed_o), 0);
    chk(rd_done_o == 1'b0, "R1 rd_done_o reset", int'(rd_done_o), 0);
    rst_ni = 1'b1;
    bus_read(2'd0, v);
    chk(v == 16'd0, "R1 status reset", int'(v), 0);
    bus_read(2'd1, v);
    chk(v == 16'd0, "R1 post count reset", int'(v), 0);

    // R3 trigger before arming is ignored
    @(negedge wr_clk); #1; trig_i = 1'b1;
    @(negedge wr_clk); #1; trig_i = 1'b0;
    @(negedge wr_clk); #1;
    chk(triggered_o == 1'b0, "R3 trigger while idle", int'(triggered_o), 0);

    // R8 start before completion is ignored
    bus_write(2'd0, 16'd1);
    bus_read(2'd0, v);
    chk(v[2] == 1'b0, "R8 start ignored before completion", int'(v[2]), 0);
    bus_read(2'd2, v);
    chk(v == 16'd0, "R8 data while inactive", int'(v), 0);

    // R9 register map
    bus_write(2'd1, 16'hA5C3);
    bus_read(2'd1, v);
    chk(v == 16'hA5C3, "R9 post count readback", int'(v), 'hA5C3);
    bus_read(2'd3, v);
    chk(v == 16'd0, "R9 unused address", int'(v), 0);

    // R2 arm overrides a simultaneous trigger
    bus_write(2'd1, 16'd0);
    @(negedge wr_clk); #1; arm_i = 1'b1; trig_i = 1'b1;
    @(negedge wr_clk); #1; arm_i = 1'b0; trig_i = 1'b0;
    chk(triggered_o == 1'b0, "R2 arm beats trigger", int'(triggered_o), 0);
    repeat (3) @(negedge wr_clk);
    #1;
    chk(completed_o == 1'b0, "R2 still waiting after arm", int'(completed_o), 0);

    // R4 R5 R6 R7 sweep, including trigger on the pointer wrap
    for (int pre = 1; pre <= 10; pre++) begin
      for (int post = 0; post <= 9; post++) begin
        run_case(pre, post);
      end
    end
    run_case(2, 20);

    // R2 re-arm clears flags
    @(negedge wr_clk); #1; arm_i = 1'b1;
    @(negedge wr_clk); #1; arm_i = 1'b0;
    chk(triggered_o == 1'b0 && completed_o == 1'b0, "R2 re-arm clears flags",
        int'({triggered_o, completed_o}), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule